// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C master. It assumes an earlier transmit phase has already claimed the bus. It clocks 8-bit frames in from a slave, answers each frame with an acknowledge level chosen by software, and closes the transfer with a stop condition.

Software drives the block through a small set of strobes and level bits:
- A read of the data register with no byte pending starts reception. This is the dummy read.
- Each later read collects one byte and clears the ready flag.
- If software falls behind, the block holds SCL low at the acknowledge clock of the next frame until the pending byte is taken.
- Setting the receive-disable bit before a read makes the frame after that byte the final one.
- After the final frame, the block parks the bus and waits for a stop request. It then generates the stop, raises a done flag and releases both lines.

Both bus lines are open-drain. Each is modelled as a drive-low enable plus a sampled line input. SCL high time starts only once the sampled line actually reads high, so a slave that stretches the clock is obeyed.

Top module: `i2c_master_rx`

## Requirements
- R1: After reset, and in idle, both drive-low enables are 0 and the ready and done flags are 0. A read strobe in idle while no byte is pending starts reception. Idle persists otherwise.
- R2: SDA is sampled once per SCL rise, and the first bit of a frame is the most significant bit of the byte.
- R3: The ready flag is set on the rising edge of the 9th SCL clock of a frame, and the data register then holds that frame's byte.
- R4: A read strobe returns the byte in the data register, and the ready flag reads 0 from the next cycle on.
- R5: During the 9th clock, SDA is driven low when the ack-level input is 0 (ACK) and released when it is 1 (NACK).
- R6: If the ready flag is still set when the next frame reaches its 9th clock, SCL is held low. The unread byte is kept. Clocking resumes after the read.
- R7: With a read for each ready flag, frames follow one another with no further command.
- R8: A read strobe with receive-disable at 1 makes the next frame to complete the last one. After that frame's 9th clock, SCL and SDA are both held low and no further clock is issued.
- R9: A stop request after the last frame's ready flag produces a stop condition: SDA rises while SCL is high. The done flag is then set with both lines released. A stop request at any other time has no effect.
- R10: Each SCL high phase lasts HALF_CYC+1 cycles from the cycle the line reads high. While a slave holds SCL low, the master waits.
- R11: SDA changes only while SCL is low, except at the stop condition.
- R12: The done flag is cleared when the next reception starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One-cycle read of the data register |
| ackLevel | input | 1 | Level for the 9th clock: 0 ACK, 1 NACK |
| rxDisable | input | 1 | Makes the following frame the last when seen with a read |
| stopReq | input | 1 | One-cycle request for a stop condition |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sclOe | output | 1 | Drive SCL low |
| sdaOe | output | 1 | Drive SDA low |
| rxData | output | DATA_W | Data register |
| dataReady | output | 1 | Received byte pending |
| stopDone | output | 1 | Stop condition completed |

## Verification
The hardest case to reach is the clock hold. The ready flag must still be set when the following frame reaches its 9th clock, so software has to stay idle through eight whole bit times while the bus runs on its own. The bench reaches it by withholding the read for 200 cycles, well past the eight bit times. It then checks that SCL stays low, no edge reaches the slave model, and the pending byte is unchanged.

A second hard case is the final frame. The receive-disable read lands while the next frame is already under way, so that frame must be the last one. Random transfer lengths, random slave clock stretching and a stray stop request mid-transfer cover how these events can fall relative to each other.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_RISE,
    ST_HIGH,
    ST_PARK,
    ST_SRISE,
    ST_SHIGH,
    ST_FREE
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadData;
    logic readAck;
  } rxStrobe_t;

endpackage

// File: rtl/i2c_mrx_dpath.sv
module i2c_mrx_dpath
  import i2c_mrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      dataReady <= 1'b0;
    end else if (strb.loadData) begin
      rxData    <= shiftReg;
      dataReady <= 1'b1;
    end else if (strb.readAck) begin
      dataReady <= 1'b0;
    end
  end

  a_r3_load_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |=> (dataReady && rxData == $past(shiftReg)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readAck && !strb.loadData) |=> !dataReady);

endmodule

// File: rtl/i2c_mrx_ctrl.sv
module i2c_mrx_ctrl
  import i2c_mrx_pkg::*;
#(
  parameter int HALF_CYC = 32,
  parameter int DATA_W   = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdStrobe,
  input  logic      ackLevel,
  input  logic      rxDisable,
  input  logic      stopReq,
  input  logic      sclIn,
  input  logic      dataReady,
  output rxStrobe_t strb,
  output logic      sclOe,
  output logic      sdaOe,
  output logic      stopDone
);

  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [BIT_W-1:0] ACK_BIT  = BIT_W'(DATA_W);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             lastArmed;
  logic             lastFrame;
  logic             stopPend;

  logic halfDone, onAck, holdAck, riseSeen, startRx, readClears, stopEnd;

  assign halfDone   = (cnt == CNT_LAST);
  assign onAck      = (bitIdx == ACK_BIT);
  assign holdAck    = onAck && dataReady;
  assign riseSeen   = (state == ST_RISE) && sclIn;
  assign startRx    = (state == ST_IDLE) && rdStrobe && !dataReady;
  assign readClears = rdStrobe && dataReady;
  assign stopEnd    = (state == ST_FREE) && halfDone;

  always_comb begin
    strb.shiftEn  = riseSeen && !onAck;
    strb.loadData = riseSeen && onAck;
    strb.readAck  = rdStrobe;
  end

  assign sclOe = (state == ST_LOW) || (state == ST_PARK);

  // phase sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startRx) begin
            state  <= ST_LOW;
            cnt    <= '0;
            bitIdx <= '0;
          end
        end
        ST_LOW: begin
          if (!halfDone) begin
            cnt <= cnt + CNT_ONE;
          end else if (!holdAck) begin
            state <= ST_RISE;
            cnt   <= '0;
          end
        end
        ST_RISE: begin
          if (sclIn) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (!halfDone) begin
            cnt <= cnt + CNT_ONE;
          end else begin
            cnt <= '0;
            if (onAck) begin
              bitIdx <= '0;
              state  <= lastFrame ? ST_PARK : ST_LOW;
            end else begin
              bitIdx <= bitIdx + BIT_W'(1);
              state  <= ST_LOW;
            end
          end
        end
        ST_PARK: begin
          if (!halfDone) begin
            cnt <= cnt + CNT_ONE;
          end else if (stopPend) begin
            state <= ST_SRISE;
            cnt   <= '0;
          end
        end
        ST_SRISE: begin
          if (sclIn) state <= ST_SHIGH;
        end
        ST_SHIGH: begin
          if (!halfDone) begin
            cnt <= cnt + CNT_ONE;
          end else begin
            state <= ST_FREE;
            cnt   <= '0;
          end
        end
        ST_FREE: begin
          if (!halfDone) cnt <= cnt + CNT_ONE;
          else           state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // last-frame and stop bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastArmed <= 1'b0;
      lastFrame <= 1'b0;
      stopPend  <= 1'b0;
      stopDone  <= 1'b0;
    end else begin
      if (startRx)
        lastArmed <= rxDisable;
      else if (readClears && rxDisable && state != ST_IDLE)
        lastArmed <= 1'b1;
      else if (strb.loadData)
        lastArmed <= 1'b0;

      if (strb.loadData && lastArmed) lastFrame <= 1'b1;
      else if (stopEnd)               lastFrame <= 1'b0;

      if (stopEnd)                     stopPend <= 1'b0;
      else if (stopReq && lastFrame)   stopPend <= 1'b1;

      if (startRx)      stopDone <= 1'b0;
      else if (stopEnd) stopDone <= 1'b1;
    end
  end

  // SDA drive: changes one cycle into an SCL-low phase, released at stop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_FREE: sdaOe <= 1'b0;
        ST_LOW:   if (cnt == CNT_ONE) sdaOe <= onAck && !ackLevel;
        ST_PARK:  if (cnt == CNT_ONE) sdaOe <= 1'b1;
        ST_SHIGH: if (halfDone)       sdaOe <= 1'b0;
        default:  sdaOe <= sdaOe;
      endcase
    end
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  a_r6_hold_scl: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && onAck && dataReady) |=> sclOe);

  a_r10_wait_line: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RISE && !sclIn) |=> (state == ST_RISE && !sclOe));

  a_r11_sda_steady: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RISE || state == ST_HIGH) |-> $stable(sdaOe));

  a_r9_stop_released: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopDone) |-> (!sclOe && !sdaOe));

endmodule

// File: rtl/i2c_master_rx.sv
module i2c_master_rx
  import i2c_mrx_pkg::*;
#(
  parameter int HALF_CYC = 32,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              ackLevel,
  input  logic              rxDisable,
  input  logic              stopReq,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              stopDone
);

  rxStrobe_t strb;

  i2c_mrx_ctrl #(.HALF_CYC(HALF_CYC), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .ackLevel(ackLevel),
    .rxDisable(rxDisable), .stopReq(stopReq), .sclIn(sclIn),
    .dataReady(dataReady), .strb(strb), .sclOe(sclOe), .sdaOe(sdaOe),
    .stopDone(stopDone)
  );

  i2c_mrx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaIn(sdaIn),
    .rxData(rxData), .dataReady(dataReady)
  );

endmodule

// File: tb/tb_i2c_master_rx.sv
module tb_i2c_master_rx;

  localparam int HALF = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, rdStrobe, ackLevel, rxDisable, stopReq;
  logic sclOe, sdaOe, dataReady, stopDone;
  logic [7:0] rxData;
  logic sclLine, sdaLine;
  logic slaveHold = 1'b0;
  logic slaveSda = 1'b1;
  bit   slaveOn = 1'b0;
  bit   stretchOn = 1'b0;
  int   fallCnt = 0, riseCnt = 0;
  logic [7:0] txBytes [16];
  logic ackSeen [16];
  int   stopCnt = 0, badEdge = 0, highBad = 0, runLen = 0;
  int   passCnt = 0, totalCnt = 0;
  bit   finished = 1'b0;

  assign sclLine = !sclOe && !slaveHold;
  assign sdaLine = !sdaOe && slaveSda;

  i2c_master_rx #(.HALF_CYC(HALF), .DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .ackLevel(ackLevel),
    .rxDisable(rxDisable), .stopReq(stopReq), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .rxData(rxData), .dataReady(dataReady),
    .stopDone(stopDone)
  );

  // slave model: shifts its byte on each SCL fall, records the ack level
  always @(negedge sclLine) begin : slaveFall
    int pos; int fr; int d;
    if (slaveOn) begin
      pos = fallCnt % 9;
      fr  = fallCnt / 9;
      fallCnt++;
      slaveSda = (pos < 8) ? txBytes[fr][7-pos] : 1'b1;
      if (stretchOn) begin
        d = $urandom_range(5, 0);
        if (d > 0) begin
          slaveHold = 1'b1;
          repeat (d) @(posedge clk);
          @(negedge clk);
          slaveHold = 1'b0;
        end
      end
    end
  end

  always @(posedge sclLine) begin : slaveRise
    int pos;
    if (slaveOn) begin
      pos = riseCnt % 9;
      if (pos == 8) begin
        ackSeen[riseCnt / 9] = sdaLine;
        if (sdaLine) begin
          slaveOn  = 1'b0;
          slaveSda = 1'b1;
        end
      end
      riseCnt++;
    end
  end

  always @(posedge sdaLine) if (sclLine === 1'b1) stopCnt++;
  always @(negedge sdaLine) if (sclLine === 1'b1) badEdge++;

  // SCL high-phase length monitor (data clocks only; stop/idle runs are longer)
  always @(negedge clk) begin
    if (sclLine === 1'b1) runLen++;
    else begin
      if (runLen > 0 && runLen < 2*HALF && runLen != HALF + 1) highBad++;
      runLen = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  function automatic bit ackOk(input int n);
    for (int k = 0; k < n; k++)
      if (ackSeen[k] !== ((k == n-1) ? 1'b1 : 1'b0)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic pulseRead(output logic [7:0] b);
    b = rxData;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic waitReady(input string req);
    int t = 0;
    while (dataReady !== 1'b1 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 4000) check(1'b0, req, "dataReady timeout", 0, 1);
  endtask

  task automatic runXfer(input int n, input int slowIdx, input bit stretch,
                         input bit stopMid);
    logic [7:0] b;
    int sBase, eBase, f0, t;
    for (int k = 0; k < n; k++) begin
      txBytes[k] = 8'($urandom);
      ackSeen[k] = 1'bx;
    end
    fallCnt = 0; riseCnt = 0; slaveSda = 1'b1; slaveOn = 1'b1;
    stretchOn = stretch;
    sBase = stopCnt; eBase = badEdge;
    ackLevel  = (n == 1);
    rxDisable = (n == 1);
    pulseRead(b);   // dummy read starts reception
    check(stopDone == 1'b0, "R12", "stopDone after start", stopDone, 0);
    for (int i = 0; i < n; i++) begin
      waitReady("R7");
      check(riseCnt == 9*(i+1), "R3", "ready at 9th rise (rise count)", riseCnt, 9*(i+1));
      if (i == n-1) break;
      if (i == n-2) begin
        ackLevel  = 1'b1;
        rxDisable = 1'b1;
      end
      if (stopMid && i == 0) begin
        stopReq = 1'b1;
        @(negedge clk);
        stopReq = 1'b0;
      end
      if (i == slowIdx) begin
        repeat (160) @(negedge clk);
        f0 = fallCnt;
        t = 0;
        for (int c = 0; c < 40; c++) begin
          if (sclOe !== 1'b1) t++;
          @(negedge clk);
        end
        check(t == 0 && fallCnt == f0, "R6", "SCL held low while byte unread", t, 0);
        check(dataReady && rxData == txBytes[i], "R6", "pending byte kept", rxData, txBytes[i]);
      end
      pulseRead(b);
      check(b == txBytes[i], "R2", "received byte", b, txBytes[i]);
      check(dataReady == 1'b0, "R4", "ready cleared by read", dataReady, 0);
      if (stopMid && i == 0)
        check(stopDone == 1'b0, "R9", "early stop request ignored", stopDone, 0);
    end
    repeat (3*HALF + 4) @(negedge clk);
    check(fallCnt == 9*n, "R8", "no clock after last frame", fallCnt, 9*n);
    check(sclOe && sdaOe, "R8", "bus parked low", {sclOe, sdaOe}, 3);
    check(ackOk(n), "R5", "ack levels seen by slave", ackSeen[n-1], 1);
    check(stopCnt == sBase, "R9", "no stop before request", stopCnt - sBase, 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    t = 0;
    while (!stopDone && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(stopDone == 1'b1, "R9", "stopDone set", stopDone, 1);
    check(!sclOe && !sdaOe, "R9", "lines released after stop", {sclOe, sdaOe}, 0);
    check(stopCnt == sBase + 1, "R9", "stop condition on bus", stopCnt - sBase, 1);
    check(dataReady == 1'b1, "R3", "last byte pending", dataReady, 1);
    pulseRead(b);
    check(b == txBytes[n-1], "R2", "last byte", b, txBytes[n-1]);
    check(dataReady == 1'b0, "R4", "ready cleared after last read", dataReady, 0);
    rxDisable = 1'b0;
    ackLevel  = 1'b0;
    check(badEdge == eBase, "R11", "SDA moved while SCL high", badEdge - eBase, 0);
    check(highBad == 0, "R10", "SCL high phase length errors", highBad, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R7", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    int n, slow;
    bit st;
    void'($urandom(32'd4242));
    rstN = 1'b0; rdStrobe = 1'b0; ackLevel = 1'b0; rxDisable = 1'b0; stopReq = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!sclOe && !sdaOe, "R1", "lines released after reset", {sclOe, sdaOe}, 0);
    check(!dataReady && !stopDone, "R1", "flags clear after reset", {dataReady, stopDone}, 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    repeat (20) @(negedge clk);
    check(!sclOe && !stopDone, "R1", "idle holds without read", {sclOe, stopDone}, 0);

    runXfer(1, -1, 1'b0, 1'b0);
    runXfer(4, -1, 1'b0, 1'b0);
    runXfer(5, 1, 1'b0, 1'b0);
    runXfer(4, -1, 1'b0, 1'b1);
    runXfer(6, 2, 1'b1, 1'b0);
    for (int r = 0; r < 6; r++) begin
      n    = $urandom_range(8, 1);
      st   = 1'($urandom_range(1, 0));
      slow = (n > 1 && $urandom_range(1, 0) == 1) ? $urandom_range(n-2, 0) : -1;
      runXfer(n, slow, st, (n > 2) && (r % 2 == 0));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule